// File: doc/BRIEF.md
# TU-12 Pointer Interpreter

This block follows the two pointer bytes of a TU-12 multiframe and works out where the V5 path overhead byte sits in the payload. A byte counter from the surrounding framer tells it which position of the 144-byte multiframe is on `byte_i`. The counter is split into four 36-byte sub-frames, and the first byte of each sub-frame is a pointer byte. The block captures the first pointer byte at position 0. At position 36 it joins that byte with the second pointer byte into one 16-bit word and evaluates the word once per multiframe.

The word is interpreted like this. Bits [15:12] are the new-data flag. Bits [11:10] are the size field. Bits [9:0] are the offset. A word is classified as one of the following:
- an immediate jump to a new value;
- a one-step increment or decrement, signalled by inverted offset bits;
- a steady value, which needs three confirmations;
- an all-ones alarm word;
- an invalid word.

Consecutive runs of alarm words raise the AIS indication. Consecutive runs of invalid words raise loss of pointer. Both indications clear when a pointer is accepted again.

The offset counts payload bytes starting with the byte after the second pointer byte, skipping the four pointer positions. The block numbers the payload bytes 0 to 139 and raises `v5_strobe_o` in the same cycle as the byte whose number equals the accepted pointer. Payload numbering, in position order:
- positions 37..71 are payload 0..34;
- positions 73..107 are payload 35..69;
- positions 109..143 are payload 70..104;
- positions 1..35 are payload 105..139.

Top module: `tu12_ptr_interp`

## Requirements
- R1: A word with new-data flag 1001, size 10 and offset 0..139 loads the offset as the pointer at the evaluation edge. It sets `ndf_event_o` for exactly the next cycle, clears AIS and loss of pointer, and marks the pointer accepted.
- R2: A word with flag 0110, size 10 and offset 0..139 that is not a step becomes the pointer only after three consecutive multiframes carry the same offset. Fewer repeats, or a different offset in between, leave `ptr_value_o` unchanged.
- R3: With an accepted pointer, a flag-0110 size-10 word increments the pointer by one, wrapping 139 to 0, when both of these hold relative to the current value: at least 3 of the I bits (9,7,5,3,1) are inverted, and fewer than 3 of the D bits are inverted.
- R4: With an accepted pointer, a flag-0110 size-10 word decrements the pointer by one, wrapping 0 to 139, when both of these hold relative to the current value: at least 3 of the D bits (8,6,4,2,0) are inverted, and fewer than 3 of the I bits are inverted.
- R5: A word is invalid if any of these holds: its size is not 10, its flag is neither 0110 nor 1001, or its offset is above 139 without forming a step. An invalid word leaves `ptr_value_o` unchanged and gives no `ndf_event_o`.
- R6: Eight consecutive invalid words raise `lop_o`, drop the accepted pointer, and clear `ais_o`. `lop_o` clears when R1 or R2 accepts a pointer.
- R7: Three consecutive all-ones words (16'hFFFF) raise `ais_o`, drop the accepted pointer, and clear `lop_o`. `ais_o` clears when R1 or R2 accepts a pointer.
- R8: `v5_strobe_o` is high, in the same cycle, exactly when all of these hold: `en_i` is high, `mf_pos_i` is a payload position whose number equals `ptr_value_o`, a pointer is accepted, and neither alarm is raised.
- R9: After reset, `ptr_value_o` is 0, no pointer is accepted, and `lop_o`, `ais_o`, `ndf_event_o` and `v5_strobe_o` are low.
- R10: Any R1, R2, R3 or R4 word restarts the invalid-word run, so 7 invalid, 1 valid, 7 invalid words do not raise `lop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | A multiframe byte is present this cycle |
| mf_pos_i | input | 8 | Position of the byte in the multiframe, 0..143 |
| byte_i | input | 8 | Multiframe byte |
| ptr_value_o | output | 10 | Current pointer, 0..139 |
| v5_strobe_o | output | 1 | Current byte is the V5 byte |
| lop_o | output | 1 | Loss of pointer |
| ais_o | output | 1 | Alarm indication (all-ones pointer) |
| ndf_event_o | output | 1 | One-cycle pulse on a new-data jump |

## Verification
The hardest situations to reach from the ports are the ones where the run counters must stop one word short. Two examples: seven invalid words followed by one good word, and two alarm words followed by a steady one. In those cases the alarm must stay down, even though a fault pattern has been going on for several multiframes. The bench builds every pointer word arithmetically, for instance a step as the current value XOR a chosen mask. It then sends whole multiframes of such words and compares the counter boundaries word by word. A sweep over all 140 pointer values checks that each value produces exactly one strobe, at the multiframe position computed from the payload numbering.

// File: rtl/tu12_ptr_pkg.sv
package tu12_ptr_pkg;
  localparam int PW = 10;
  localparam logic [3:0] NDF_OFF = 4'b0110;
  localparam logic [3:0] NDF_ON  = 4'b1001;
  localparam logic [1:0] SZ_TU12 = 2'b10;
  localparam logic [PW-1:0] I_MASK = 10'h2AA;
  localparam logic [PW-1:0] D_MASK = 10'h155;
  localparam int STEP_VOTE = 3;

  typedef enum logic [2:0] {
    K_BAD,
    K_AIS,
    K_NEW,
    K_INC,
    K_DEC,
    K_NORM
  } kind_e;
endpackage

// File: rtl/tu12_ptr_decode.sv
module tu12_ptr_decode
  import tu12_ptr_pkg::*;
#(
  parameter int PTR_MAX = 139
) (
  input  logic [15:0]   word_i,
  input  logic [PW-1:0] cur_i,
  input  logic          cur_ok_i,
  output kind_e         kind_o
);
  localparam logic [PW-1:0] PMAX_W = PW'(PTR_MAX);

  logic [3:0]    ndf;
  logic [1:0]    size;
  logic [PW-1:0] off;
  logic [PW-1:0] diff;
  logic          fmt_norm;
  logic          in_rng;
  logic          i_vote;
  logic          d_vote;

  assign ndf      = word_i[15:12];
  assign size     = word_i[11:10];
  assign off      = word_i[PW-1:0];
  assign diff     = off ^ cur_i;
  assign fmt_norm = (ndf == NDF_OFF) && (size == SZ_TU12);
  assign in_rng   = off <= PMAX_W;
  assign i_vote   = $countones(diff & I_MASK) >= STEP_VOTE;
  assign d_vote   = $countones(diff & D_MASK) >= STEP_VOTE;

  always_comb begin
    kind_o = K_BAD;
    if (&word_i) begin
      kind_o = K_AIS;
    end else if ((ndf == NDF_ON) && (size == SZ_TU12) && in_rng) begin
      kind_o = K_NEW;
    end else if (fmt_norm && cur_ok_i && i_vote && !d_vote) begin
      kind_o = K_INC;
    end else if (fmt_norm && cur_ok_i && d_vote && !i_vote) begin
      kind_o = K_DEC;
    end else if (fmt_norm && in_rng) begin
      kind_o = K_NORM;
    end
  end
endmodule

// File: rtl/tu12_ptr_track.sv
module tu12_ptr_track
  import tu12_ptr_pkg::*;
#(
  parameter int PTR_MAX = 139,
  parameter int NORM_N  = 3,
  parameter int LOP_N   = 8,
  parameter int AIS_N   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eval_i,
  input  kind_e         kind_i,
  input  logic [PW-1:0] off_i,
  output logic [PW-1:0] ptr_o,
  output logic          ok_o,
  output logic          lop_o,
  output logic          ais_o,
  output logic          ndf_o
);
  localparam int LW = (LOP_N > 2) ? $clog2(LOP_N) : 1;
  localparam int AW = (AIS_N > 2) ? $clog2(AIS_N) : 1;
  localparam int CW = (NORM_N > 2) ? $clog2(NORM_N) : 1;
  localparam logic [PW-1:0] PMAX_W = PW'(PTR_MAX);
  localparam logic [LW-1:0] LOP_M1 = LW'(LOP_N - 1);
  localparam logic [AW-1:0] AIS_M1 = AW'(AIS_N - 1);
  localparam logic [CW-1:0] NRM_M1 = CW'(NORM_N - 1);

  logic [PW-1:0] ptr_q, cand_q;
  logic [LW-1:0] inv_q;
  logic [AW-1:0] ais_n_q;
  logic [CW-1:0] cand_n_q;
  logic          ok_q, lop_q, ais_q, ndf_q;
  logic          cand_hit;

  assign cand_hit = (cand_n_q != '0) && (off_i == cand_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      cand_q   <= '0;
      inv_q    <= '0;
      ais_n_q  <= '0;
      cand_n_q <= '0;
      ok_q     <= 1'b0;
      lop_q    <= 1'b0;
      ais_q    <= 1'b0;
      ndf_q    <= 1'b0;
    end else begin
      ndf_q <= 1'b0;
      if (eval_i) begin
        unique case (kind_i)
          K_AIS: begin
            inv_q    <= '0;
            cand_n_q <= '0;
            if (ais_n_q >= AIS_M1) begin
              ais_q <= 1'b1;
              lop_q <= 1'b0;
              ok_q  <= 1'b0;
            end else begin
              ais_n_q <= ais_n_q + 1'b1;
            end
          end
          K_NEW: begin
            ptr_q    <= off_i;
            ok_q     <= 1'b1;
            lop_q    <= 1'b0;
            ais_q    <= 1'b0;
            inv_q    <= '0;
            ais_n_q  <= '0;
            cand_n_q <= '0;
            ndf_q    <= 1'b1;
          end
          K_INC: begin
            ptr_q    <= (ptr_q == PMAX_W) ? '0 : ptr_q + 1'b1;
            inv_q    <= '0;
            ais_n_q  <= '0;
            cand_n_q <= '0;
          end
          K_DEC: begin
            ptr_q    <= (ptr_q == '0) ? PMAX_W : ptr_q - 1'b1;
            inv_q    <= '0;
            ais_n_q  <= '0;
            cand_n_q <= '0;
          end
          K_NORM: begin
            inv_q   <= '0;
            ais_n_q <= '0;
            if (!cand_hit) begin
              cand_q   <= off_i;
              cand_n_q <= CW'(1);
            end else if (cand_n_q >= NRM_M1) begin
              ptr_q <= off_i;
              ok_q  <= 1'b1;
              lop_q <= 1'b0;
              ais_q <= 1'b0;
            end else begin
              cand_n_q <= cand_n_q + 1'b1;
            end
          end
          default: begin
            cand_n_q <= '0;
            ais_n_q  <= '0;
            if (inv_q >= LOP_M1) begin
              lop_q <= 1'b1;
              ais_q <= 1'b0;
              ok_q  <= 1'b0;
            end else begin
              inv_q <= inv_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

  assign ptr_o = ptr_q;
  assign ok_o  = ok_q;
  assign lop_o = lop_q;
  assign ais_o = ais_q;
  assign ndf_o = ndf_q;
endmodule

// File: rtl/tu12_ptr_locate.sv
module tu12_ptr_locate
  import tu12_ptr_pkg::*;
#(
  parameter int SUB_LEN = 36
) (
  input  logic [7:0]    pos_i,
  output logic          pay_o,
  output logic [PW-1:0] idx_o
);
  int unsigned pos_u, q_u, r_u;

  // sub-frame after the second pointer byte is payload block 0
  always_comb begin
    pos_u = 32'(pos_i);
    q_u   = pos_u / SUB_LEN;
    r_u   = pos_u % SUB_LEN;
    pay_o = (r_u != 0) && (q_u < 4);
    idx_o = PW'(((q_u + 3) % 4) * (SUB_LEN - 1) + r_u - 1);
  end
endmodule

// File: rtl/tu12_ptr_interp.sv
module tu12_ptr_interp
  import tu12_ptr_pkg::*;
#(
  parameter int SUB_LEN = 36,
  parameter int NORM_N  = 3,
  parameter int LOP_N   = 8,
  parameter int AIS_N   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [7:0]    mf_pos_i,
  input  logic [7:0]    byte_i,
  output logic [PW-1:0] ptr_value_o,
  output logic          v5_strobe_o,
  output logic          lop_o,
  output logic          ais_o,
  output logic          ndf_event_o
);
  localparam int PTR_MAX = 4 * (SUB_LEN - 1) - 1;
  localparam logic [7:0] P1_POS = 8'd0;
  localparam logic [7:0] P2_POS = 8'(SUB_LEN);

  logic [7:0]    p1_q;
  logic [15:0]   word;
  logic          eval;
  kind_e         kind;
  logic [PW-1:0] ptr;
  logic          ok, lop, ais, ndf;
  logic          pay;
  logic [PW-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p1_q <= '0;
    end else if (en_i && (mf_pos_i == P1_POS)) begin
      p1_q <= byte_i;
    end
  end

  assign eval = en_i && (mf_pos_i == P2_POS);
  assign word = {p1_q, byte_i};

  tu12_ptr_decode #(.PTR_MAX(PTR_MAX)) u_dec (
    .word_i  (word),
    .cur_i   (ptr),
    .cur_ok_i(ok),
    .kind_o  (kind)
  );

  tu12_ptr_track #(
    .PTR_MAX(PTR_MAX),
    .NORM_N (NORM_N),
    .LOP_N  (LOP_N),
    .AIS_N  (AIS_N)
  ) u_trk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .eval_i(eval),
    .kind_i(kind),
    .off_i (word[PW-1:0]),
    .ptr_o (ptr),
    .ok_o  (ok),
    .lop_o (lop),
    .ais_o (ais),
    .ndf_o (ndf)
  );

  tu12_ptr_locate #(.SUB_LEN(SUB_LEN)) u_loc (
    .pos_i(mf_pos_i),
    .pay_o(pay),
    .idx_o(idx)
  );

  assign ptr_value_o = ptr;
  assign v5_strobe_o = en_i && pay && (idx == ptr) && ok && !lop && !ais;
  assign lop_o       = lop;
  assign ais_o       = ais;
  assign ndf_event_o = ndf;
endmodule

// File: rtl/tu12_ptr_interp_chk.sv
module tu12_ptr_interp_chk #(
  parameter int SUB_LEN = 36
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [7:0] mf_pos_i,
  input logic [9:0] ptr_value_o,
  input logic       v5_strobe_o,
  input logic       lop_o,
  input logic       ais_o,
  input logic       ndf_event_o
);
  localparam logic [9:0] PMAX_W = 10'(4 * (SUB_LEN - 1) - 1);
  localparam logic [7:0] SUB_W  = 8'(SUB_LEN);

  logic at_p2;
  assign at_p2 = en_i && (mf_pos_i == SUB_W);

  a_r8_strobe_on_payload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v5_strobe_o |-> en_i && ((mf_pos_i % SUB_W) != 8'd0));

  a_r8_strobe_no_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v5_strobe_o |-> !lop_o && !ais_o);

  a_r6_r7_alarm_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lop_o && ais_o));

  a_r5_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_value_o <= PMAX_W);

  a_r1_ndf_after_p2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ndf_event_o |-> $past(at_p2));

  a_r3_ptr_moves_on_p2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(at_p2) |-> $stable(ptr_value_o));

  a_r6_lop_rises_on_p2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lop_o) |-> $past(at_p2));

  a_r7_ais_rises_on_p2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ais_o) |-> $past(at_p2));
endmodule

bind tu12_ptr_interp tu12_ptr_interp_chk #(.SUB_LEN(SUB_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .mf_pos_i   (mf_pos_i),
  .ptr_value_o(ptr_value_o),
  .v5_strobe_o(v5_strobe_o),
  .lop_o      (lop_o),
  .ais_o      (ais_o),
  .ndf_event_o(ndf_event_o)
);

// File: tb/tb_tu12_ptr_interp.sv
module tb_tu12_ptr_interp;
  localparam int CLK_P = 10;
  localparam int SUB = 36;
  localparam int MF = 4 * SUB;
  localparam int PAY = SUB - 1;
  localparam int PMAX = 4 * PAY - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] pos = '0;
  logic [7:0] dbyte = '0;
  logic [9:0] ptr;
  logic       strobe, lop, ais, ndf;

  int n_chk = 0;
  int n_fail = 0;
  int s_cnt, s_pos;
  bit n_seen;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  tu12_ptr_interp dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .mf_pos_i   (pos),
    .byte_i     (dbyte),
    .ptr_value_o(ptr),
    .v5_strobe_o(strobe),
    .lop_o      (lop),
    .ais_o      (ais),
    .ndf_event_o(ndf)
  );

  function automatic logic [15:0] nw(int v);
    return {4'b0110, 2'b10, 10'(v)};
  endfunction

  function automatic logic [15:0] jw(int v);
    return {4'b1001, 2'b10, 10'(v)};
  endfunction

  function automatic int pos_of(int p);
    return ((p / PAY + 1) % 4) * SUB + (p % PAY) + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic frame(logic [15:0] w);
    s_cnt = 0;
    s_pos = -1;
    n_seen = 1'b0;
    for (int p = 0; p < MF; p++) begin
      @(negedge clk);
      en = 1'b1;
      pos = 8'(p);
      dbyte = (p == 0) ? w[15:8] : ((p == SUB) ? w[7:0] : 8'h00);
      #1;
      if (strobe) begin
        s_cnt++;
        s_pos = p;
      end
      if (ndf) n_seen = 1'b1;
    end
    @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 ptr", int'(ptr), 0);
    chk("R9 lop", int'(lop), 0);
    chk("R9 ais", int'(ais), 0);
    chk("R9 ndf", int'(ndf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 strobe", int'(strobe), 0);

    // R2 acceptance needs three repeats
    frame(nw(50));
    chk("R2 one repeat ptr", int'(ptr), 0);
    chk("R8 no strobe before accept", s_cnt, 0);
    frame(nw(50));
    chk("R2 two repeats ptr", int'(ptr), 0);
    frame(nw(50));
    chk("R2 three repeats ptr", int'(ptr), 50);
    frame(nw(50));
    chk("R8 strobe pos", s_pos, pos_of(50));

    // R1 and R8 sweep over every pointer value
    for (int p = 0; p <= PMAX; p++) begin
      frame(jw(p));
      chk("R1 jump ptr", int'(ptr), p);
      chk("R1 ndf pulse", int'(n_seen), 1);
      frame(nw(p));
      chk("R8 strobe count", s_cnt, 1);
      chk("R8 strobe pos", s_pos, pos_of(p));
    end

    // R3 and R4 wrap
    frame(nw(PMAX ^ 10'h2AA));
    chk("R3 inc wrap", int'(ptr), 0);
    frame(nw(0 ^ 10'h155));
    chk("R4 dec wrap", int'(ptr), PMAX);

    frame(jw(50));
    frame(nw(50 ^ 10'h2AA));
    chk("R3 inc all five", int'(ptr), 51);
    frame(nw(51 ^ 10'h2A0));
    chk("R3 inc three of five", int'(ptr), 52);
    frame(nw(52 ^ 10'h155));
    chk("R4 dec", int'(ptr), 51);
    chk("R4 no ndf on step", int'(n_seen), 0);

    // R5 invalid words
    frame(nw(51 ^ 10'h3F0));
    chk("R5 split vote", int'(ptr), 51);
    frame({4'b1001, 2'b11, 10'd20});
    chk("R5 bad size jump", int'(ptr), 51);
    chk("R5 no ndf", int'(n_seen), 0);
    frame(jw(140));
    chk("R5 out of range jump", int'(ptr), 51);
    frame({4'b0110, 2'b00, 10'd51});
    chk("R5 bad size norm", int'(ptr), 51);
    frame({4'b0000, 2'b10, 10'd20});
    chk("R5 bad flag", int'(ptr), 51);

    // R10 valid word restarts invalid run
    frame(nw(51));
    for (int k = 0; k < 7; k++) frame({4'b0110, 2'b01, 10'd3});
    chk("R10 seven invalid", int'(lop), 0);
    frame(nw(51));
    for (int k = 0; k < 7; k++) frame({4'b0110, 2'b01, 10'd3});
    chk("R10 restarted run", int'(lop), 0);

    // R6 loss of pointer
    frame({4'b0110, 2'b01, 10'd3});
    chk("R6 eighth invalid", int'(lop), 1);
    frame(nw(51));
    chk("R8 no strobe in lop", s_cnt, 0);
    frame(nw(51));
    chk("R6 lop held", int'(lop), 1);
    frame(nw(51));
    chk("R6 lop cleared", int'(lop), 0);
    frame(nw(51));
    chk("R6 strobe back", s_pos, pos_of(51));

    // R2 interrupted candidate
    frame(nw(60));
    frame(nw(60));
    frame(nw(61));
    frame(nw(61));
    chk("R2 interrupted", int'(ptr), 51);
    frame(nw(61));
    chk("R2 new value", int'(ptr), 61);

    // R7 alarm indication
    frame(16'hFFFF);
    frame(16'hFFFF);
    chk("R7 two all-ones", int'(ais), 0);
    frame(16'hFFFF);
    chk("R7 three all-ones", int'(ais), 1);
    chk("R7 lop low", int'(lop), 0);
    frame(16'hFFFF);
    chk("R8 no strobe in ais", s_cnt, 0);
    frame(jw(70));
    chk("R7 ais cleared", int'(ais), 0);
    chk("R1 jump after ais", int'(ptr), 70);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule